// File: doc/BRIEF.md
# Digital Input Debounce Channel

This block conditions one asynchronous digital input for use inside a synchronous design. The raw pin first passes through a chain of flip-flops clocked by the system clock. It then feeds a small saturating up/down counter. The counter moves only on a slow enable tick. The tick is picked, for each channel, from a set of shared enables that a central divider produces elsewhere.

A two-bit mode setting decides which signal drives the channel output:
- the raw pin itself;
- the synchronized copy of the pin;
- the debounced state held by the counter.

The mode and the tick source are configuration. They are set while the channel is held in reset or is idle, and they stay fixed while it runs. A system with many inputs instantiates one copy of this block per input and wires every copy to the same tick bus.

Top module: `din_filter_chan`

## Requirements
- R1: `sync_out` reproduces `din_raw` delayed by exactly two rising edges of `clk`.
- R2: On an edge where the selected tick is high, the count increments by one if `sync_out` is 1 and decrements by one if `sync_out` is 0.
- R3: The count saturates at 0 and at 16, so it never leaves the range 0..16. After a long high period, a falling input still needs the full 16 ticks to clear the filter.
- R4: The count changes only on edges where `tick_en[src_sel]` is 1. `src_sel` is a binary index 0..7 into `tick_en`, and the other enables have no effect on the count.
- R5: The debounced state goes to 1 on the edge where the count reaches 16, goes to 0 on the edge where the count reaches 0, and otherwise holds its value. Input pulses shorter than 16 ticks are rejected.
- R6: With `mode_cfg` equal to 1 or 0, `filt_out` follows `din_raw` combinationally, without any clock edge.
- R7: With `mode_cfg` equal to 2, `filt_out` equals `sync_out`.
- R8: With `mode_cfg` equal to 3, `filt_out` is the debounced state. With all ticks held high, it changes 18 edges after a change of `din_raw` that was set up before the first of those edges.
- R9: While `rst_n` is 0, both synchronizer stages, the count and the debounced state are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din_raw | input | 1 | Asynchronous input pin |
| tick_en | input | 8 | Shared enable ticks from the central divider, one per source |
| mode_cfg | input | 2 | Output path: 0/1 raw, 2 synchronized, 3 debounced |
| src_sel | input | 3 | Index of the tick source that steps the counter |
| sync_out | output | 1 | Input after the two-stage synchronizer |
| filt_out | output | 1 | Channel output selected by `mode_cfg` |

## Verification
The raw path is due without any clock edge, so it is sampled a short delay after the input is driven. The synchronized copy is due on the second edge after the pin changes. The debounced output is due on the eighteenth edge when every tick is high, or on the sixteenth edge when the synchronizer is already settled and ticks are then restored.

All inputs change a few time units after a rising edge, and all outputs are sampled there as well. Each check is therefore placed at an exact edge count, one edge before the due edge and at the due edge itself. With a sparse tick of one pulse every four cycles, the checks use generous windows on either side of the expected rise, so that a wrong source choice shows as an early or missing rise.

// File: rtl/din_filt_pkg.sv
package din_filt_pkg;

  // counter geometry shared by every channel
  parameter int FILT_CNT_W = 5;
  parameter int FILT_CNT_MAX = 16;

  typedef enum logic [1:0] {
    FMODE_RAW_ALT = 2'd0,
    FMODE_RAW     = 2'd1,
    FMODE_SYNC    = 2'd2,
    FMODE_FILT    = 2'd3
  } fmode_e;

  localparam logic [FILT_CNT_W-1:0] CNT_TOP = FILT_CNT_W'(FILT_CNT_MAX);
  localparam logic [FILT_CNT_W-1:0] CNT_BOT = '0;

  // one saturating step of the count
  function automatic logic [FILT_CNT_W-1:0] cnt_step(
      input logic [FILT_CNT_W-1:0] cur, input logic up);
    logic [FILT_CNT_W-1:0] nxt;
    nxt = cur;
    if (up && (cur != CNT_TOP)) nxt = cur + 1'b1;
    else if (!up && (cur != CNT_BOT)) nxt = cur - 1'b1;
    return nxt;
  endfunction

  // hysteresis: set at top, clear at bottom, hold elsewhere
  function automatic logic state_next(
      input logic [FILT_CNT_W-1:0] nxt_cnt, input logic cur_state);
    logic s;
    s = cur_state;
    if (nxt_cnt == CNT_TOP) s = 1'b1;
    else if (nxt_cnt == CNT_BOT) s = 1'b0;
    return s;
  endfunction

endpackage

// File: rtl/din_sync_chain.sv
module din_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_first,
  output logic d_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_async;
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign d_first = chain_q[0];
  assign d_sync  = chain_q[STAGES-1];
endmodule

// File: rtl/din_tick_pick.sv
module din_tick_pick #(
  parameter int NUM_SRC = 8,
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] tick_en,
  input  logic [SEL_W-1:0]   sel,
  output logic               tick
);
  always_comb begin
    tick = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (sel == SEL_W'(k)) tick = tick_en[k];
    end
  end
endmodule

// File: rtl/din_updown_filter.sv
module din_updown_filter
  import din_filt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step,
  input  logic                  level,
  output logic [FILT_CNT_W-1:0] cnt,
  output logic                  state
);
  logic [FILT_CNT_W-1:0] cnt_q, cnt_d;
  logic                  state_q, state_d;

  always_comb begin
    cnt_d   = cnt_q;
    state_d = state_q;
    if (step) begin
      cnt_d   = cnt_step(cnt_q, level);
      state_d = state_next(cnt_d, state_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      state_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      state_q <= state_d;
    end
  end

  assign cnt   = cnt_q;
  assign state = state_q;
endmodule

// File: rtl/din_filter_chan.sv
module din_filter_chan
  import din_filt_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               din_raw,
  input  logic [NUM_SRC-1:0] tick_en,
  input  logic [1:0]         mode_cfg,
  input  logic [SEL_W-1:0]   src_sel,
  output logic               sync_out,
  output logic               filt_out
);
  // named internal events for the checker
  logic                  sync_first;
  logic                  tick_hit;
  logic [FILT_CNT_W-1:0] flt_cnt;
  logic                  flt_state;

  din_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (din_raw),
    .d_first (sync_first),
    .d_sync  (sync_out)
  );

  din_tick_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .tick_en (tick_en),
    .sel     (src_sel),
    .tick    (tick_hit)
  );

  din_updown_filter u_flt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (tick_hit),
    .level (sync_out),
    .cnt   (flt_cnt),
    .state (flt_state)
  );

  always_comb begin
    unique case (fmode_e'(mode_cfg))
      FMODE_SYNC: filt_out = sync_out;
      FMODE_FILT: filt_out = flt_state;
      default:    filt_out = din_raw;
    endcase
  end
endmodule

// File: rtl/din_filter_chan_chk.sv
module din_filter_chan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       din_raw,
  input logic [1:0] mode_cfg,
  input logic       sync_first,
  input logic       sync_out,
  input logic       tick_hit,
  input logic [4:0] flt_cnt,
  input logic       flt_state,
  input logic       filt_out
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    flt_cnt <= 5'd16);

  a_r1_second_stage: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out == $past(sync_first));

  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_hit |=> $stable(flt_cnt) && $stable(flt_state));

  a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_hit && sync_out && flt_cnt < 5'd16) |=> flt_cnt == $past(flt_cnt) + 5'd1);

  a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_hit && !sync_out && flt_cnt > 5'd0) |=> flt_cnt == $past(flt_cnt) - 5'd1);

  a_r5_set_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_state) |-> flt_cnt == 5'd16);

  a_r5_clear_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flt_state) |-> flt_cnt == 5'd0);

  a_r7_sync_path: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cfg == 2'd2 |-> filt_out == sync_out);

  a_r8_filter_path: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cfg == 2'd3 |-> filt_out == flt_state);

  a_r6_raw_path: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cfg < 2'd2 |-> filt_out == din_raw);
endmodule

bind din_filter_chan din_filter_chan_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .din_raw    (din_raw),
  .mode_cfg   (mode_cfg),
  .sync_first (sync_first),
  .sync_out   (sync_out),
  .tick_hit   (tick_hit),
  .flt_cnt    (flt_cnt),
  .flt_state  (flt_state),
  .filt_out   (filt_out)
);

// File: tb/din_filter_chan_tb.sv
module din_filter_chan_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       din_raw = 1'b0;
  logic [7:0] tick_en = 8'h00;
  logic [1:0] mode_cfg = 2'd3;
  logic [2:0] src_sel = 3'd0;
  logic       sync_out, filt_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int tick_kind = 0; // 0 all high, 1 all low, 2 bit5 sparse + others high

  always #5 clk = ~clk;

  din_filter_chan u_dut (
    .clk(clk), .rst_n(rst_n), .din_raw(din_raw), .tick_en(tick_en),
    .mode_cfg(mode_cfg), .src_sel(src_sel),
    .sync_out(sync_out), .filt_out(filt_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic apply_ticks();
    case (tick_kind)
      0: tick_en = 8'hFF;
      1: tick_en = 8'h00;
      default: tick_en = {2'b11, ((cyc % 4) == 0), 5'b11111};
    endcase
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      cyc++;
      apply_ticks();
    end
  endtask

  task automatic restart(input logic [1:0] m, input logic [2:0] s, input int tk);
    @(posedge clk); #2;
    rst_n = 1'b0;
    din_raw = 1'b0;
    mode_cfg = m;
    src_sel = s;
    tick_kind = tk;
    apply_ticks();
    steps(3);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    @(posedge clk); #2;
    rst_n = 1'b0; mode_cfg = 2'd3; din_raw = 1'b1; tick_kind = 0; apply_ticks();
    steps(4);
    check("R9 sync_out in reset", sync_out, 1'b0);
    check("R9 filt_out in reset", filt_out, 1'b0);
    din_raw = 1'b0;
    steps(1);
  endtask

  task automatic t_raw(input logic [1:0] m);
    restart(m, 3'd0, 0);
    din_raw = 1'b1; #1;
    check(m == 2'd0 ? "R6 mode0 raw high" : "R6 mode1 raw high", filt_out, 1'b1);
    check("R1 sync_out not yet", sync_out, 1'b0);
    din_raw = 1'b0; #1;
    check("R6 raw low", filt_out, 1'b0);
  endtask

  task automatic t_sync();
    restart(2'd2, 3'd0, 0);
    din_raw = 1'b1;
    steps(1);
    check("R1 one edge still low", sync_out, 1'b0);
    check("R7 follows sync low", filt_out, 1'b0);
    steps(1);
    check("R1 two edges high", sync_out, 1'b1);
    check("R7 follows sync high", filt_out, 1'b1);
  endtask

  task automatic t_filter_rise_fall();
    restart(2'd3, 3'd0, 0);
    din_raw = 1'b1;
    steps(17);
    check("R8 rise not before edge 18", filt_out, 1'b0);
    steps(1);
    check("R8 rise at edge 18", filt_out, 1'b1);
    steps(22);
    din_raw = 1'b0;
    steps(17);
    check("R3 saturated fall not before edge 18", filt_out, 1'b1);
    steps(1);
    check("R5 fall at edge 18", filt_out, 1'b0);
  endtask

  task automatic t_glitch();
    logic seen;
    restart(2'd3, 3'd0, 0);
    seen = 1'b0;
    din_raw = 1'b1;
    steps(10);
    din_raw = 1'b0;
    for (int i = 0; i < 30; i++) begin
      steps(1);
      if (filt_out) seen = 1'b1;
    end
    check("R5 short pulse rejected", seen, 1'b0);
  endtask

  task automatic t_no_tick();
    restart(2'd3, 3'd0, 1);
    din_raw = 1'b1;
    steps(100);
    check("R4 no tick keeps output low", filt_out, 1'b0);
    tick_kind = 0; apply_ticks();
    steps(15);
    check("R2 count held at 0 without ticks", filt_out, 1'b0);
    steps(1);
    check("R2 sixteen ticks reach top", filt_out, 1'b1);
  endtask

  task automatic t_select();
    restart(2'd3, 3'd5, 2);
    din_raw = 1'b1;
    steps(40);
    check("R4 other enables ignored", filt_out, 1'b0);
    steps(40);
    check("R4 selected sparse tick fills", filt_out, 1'b1);
  endtask

  initial begin
    t_reset();
    t_raw(2'd1);
    t_raw(2'd0);
    t_sync();
    t_filter_rise_fall();
    t_glitch();
    t_no_tick();
    t_select();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule